// File: doc/BRIEF.md
# AXI ID-Filtered Traffic Event Generator

This block sits beside an AXI port and watches three channel handshakes: read address, write address and read data. For each handshake whose transaction ID agrees with a programmed reference ID on every bit selected by a programmed mask, it raises a single-cycle event pulse. There is one pulse output per class: read transactions, write transactions and read data beats. The block never drives the bus. It only samples valid, ready and ID.

The pulses feed a bank of event counters. The read-transaction pulse goes to counter 2, the write-transaction pulse to counter 3 and the read-beat pulse to counter 4. Each is selected there by event code 73. Software programs two 32-bit registers through a simple write port with a combinational read-back. The control register holds the three enables and the mask. The ID register holds the reference ID.

The ID width is a parameter, `ID_W`, with a default of 18. It must stay at or below 29 so that the mask field does not overlap the enable bits.

Top module: `axi_idflt_events`

## Requirements
- R1: While `rst_ni` is low, both registers read 0 and all three pulse outputs are 0.
- R2: The control register sits at byte offset 0x00. Bit 31 enables read-transaction events, bit 30 enables write-transaction events and bit 29 enables read-beat events. Bits `ID_W-1:0` hold the mask. All other bits read 0.
- R3: The ID register sits at byte offset 0x04, with the reference ID in bits `ID_W-1:0` and all other bits reading 0. A write to any other offset changes no register, and any other offset reads 0.
- R4: An ID matches when `((txn_id ^ ref_id) & mask) == 0`. A mask of 0 therefore matches every ID.
- R5: An AR handshake (`ar_valid_i` and `ar_ready_i` both high at a rising edge) with a matching ID and the read-transaction enable set gives `ev_rd_txn_o` high for exactly the next cycle.
- R6: An AW handshake with a matching ID and the write-transaction enable set gives `ev_wr_txn_o` high for exactly the next cycle.
- R7: Every R handshake with a matching ID and the read-beat enable set gives one `ev_rd_beat_o` cycle. Back-to-back matching beats give back-to-back pulses, and a non-matching beat within a burst gives none.
- R8: With an enable at 0, its output stays 0. Valid without ready, or ready without valid, never produces a pulse.
- R9: A handshake in the same cycle as a configuration write is judged against the configuration held before that write. The new value governs handshakes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Read-back of the register at `cfg_addr_i` |
| ar_valid_i | input | 1 | Read address valid |
| ar_ready_i | input | 1 | Read address ready |
| ar_id_i | input | ID_W | Read address ID |
| aw_valid_i | input | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_id_i | input | ID_W | Write address ID |
| r_valid_i | input | 1 | Read data valid |
| r_ready_i | input | 1 | Read data ready |
| r_id_i | input | ID_W | Read data ID |
| ev_rd_txn_o | output | 1 | Filtered read-transaction pulse |
| ev_wr_txn_o | output | 1 | Filtered write-transaction pulse |
| ev_rd_beat_o | output | 1 | Filtered read-beat pulse |

## Verification
The hardest case to reach is a configuration write that lands in the same clock edge as a qualifying handshake. Only that case shows whether the match uses the old or the new register contents. The bench first arms all filters with a matching ID. It then, in one cycle, drives a write that clears every enable together with an AR handshake, and expects a pulse. A second handshake one cycle later must give none. A bursty read stream with one mismatching ID in the middle of the burst checks that the beat filter decides per cycle and keeps no state between beats.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned NUM_EV   = 3;
  localparam logic [7:0]  CTRL_OFS = 8'h00;
  localparam logic [7:0]  ID_OFS   = 8'h04;
  localparam int unsigned EN_TOP   = 31;  // enable for event k sits at EN_TOP-k

  typedef enum int unsigned {
    EV_RD_TXN  = 0,
    EV_WR_TXN  = 1,
    EV_RD_BEAT = 2
  } ev_kind_e;

  function automatic int unsigned en_bit(input int unsigned k);
    return EN_TOP - k;
  endfunction
endpackage

// File: rtl/axf_cfg_regs.sv
module axf_cfg_regs
  import axf_pkg::*;
#(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [CFG_W-1:0]    wdata_i,
  output logic [CFG_W-1:0]    rdata_o,
  output logic [NUM_EV-1:0]   en_o,
  output logic [ID_W-1:0]     mask_o,
  output logic [ID_W-1:0]     ref_id_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] ID_A   = ADDR_W'(ID_OFS);

  logic [NUM_EV-1:0] en_q;
  logic [ID_W-1:0]   mask_q, id_q;
  logic              ctrl_wr, id_wr;

  assign ctrl_wr = we_i && (addr_i == CTRL_A);
  assign id_wr   = we_i && (addr_i == ID_A);

  for (genvar k = 0; k < NUM_EV; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      en_q[k] <= 1'b0;
      else if (ctrl_wr) en_q[k] <= wdata_i[en_bit(k)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      id_q   <= '0;
    end else begin
      if (ctrl_wr) mask_q <= wdata_i[ID_W-1:0];
      if (id_wr)   id_q   <= wdata_i[ID_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_A) begin
      rdata_o[ID_W-1:0] = mask_q;
      for (int k = 0; k < NUM_EV; k++) rdata_o[en_bit(k)] = en_q[k];
    end else if (addr_i == ID_A) begin
      rdata_o[ID_W-1:0] = id_q;
    end
  end

  assign en_o     = en_q;
  assign mask_o   = mask_q;
  assign ref_id_o = id_q;

  p_id_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(id_wr) |-> (ref_id_o == $past(wdata_i[ID_W-1:0])));

  p_stray_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i && addr_i != CTRL_A && addr_i != ID_A)
      |-> ($stable(en_o) && $stable(mask_o) && $stable(ref_id_o)));
endmodule

// File: rtl/axf_id_match.sv
module axf_id_match #(
  parameter int unsigned ID_W = 18
) (
  input  logic [ID_W-1:0] txn_id_i,
  input  logic [ID_W-1:0] ref_id_i,
  input  logic [ID_W-1:0] mask_i,
  output logic            match_o
);
  logic [ID_W-1:0] diff;

  assign diff    = (txn_id_i ^ ref_id_i) & mask_i;
  assign match_o = ~|diff;

  always_comb begin
    if (mask_i == '0) p_open_mask_r4: assert (match_o);
  end
endmodule

// File: rtl/axf_event_pulse.sv
module axf_event_pulse #(
  parameter int unsigned ID_W = 18
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            ready_i,
  input  logic [ID_W-1:0] txn_id_i,
  input  logic            en_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] ref_id_i,
  output logic            pulse_o
);
  logic hit, pulse_q;

  axf_id_match #(.ID_W(ID_W)) u_match (
    .txn_id_i (txn_id_i),
    .ref_id_i (ref_id_i),
    .mask_i   (mask_i),
    .match_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= en_i && valid_i && ready_i && hit;
  end

  assign pulse_o = pulse_q;

  p_needs_handshake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(valid_i && ready_i));

  p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !pulse_o);
endmodule

// File: rtl/axi_idflt_events.sv
module axi_idflt_events
  import axf_pkg::*;
#(
  parameter int unsigned ID_W   = 18,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              ar_valid_i,
  input  logic              ar_ready_i,
  input  logic [ID_W-1:0]   ar_id_i,
  input  logic              aw_valid_i,
  input  logic              aw_ready_i,
  input  logic [ID_W-1:0]   aw_id_i,
  input  logic              r_valid_i,
  input  logic              r_ready_i,
  input  logic [ID_W-1:0]   r_id_i,
  output logic              ev_rd_txn_o,
  output logic              ev_wr_txn_o,
  output logic              ev_rd_beat_o
);
  logic [NUM_EV-1:0] en, vld, rdy, pulse;
  logic [ID_W-1:0]   mask, ref_id;
  logic [ID_W-1:0]   tid [NUM_EV];

  axf_cfg_regs #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .en_o     (en),
    .mask_o   (mask),
    .ref_id_o (ref_id)
  );

  assign vld[EV_RD_TXN]  = ar_valid_i;
  assign rdy[EV_RD_TXN]  = ar_ready_i;
  assign tid[EV_RD_TXN]  = ar_id_i;
  assign vld[EV_WR_TXN]  = aw_valid_i;
  assign rdy[EV_WR_TXN]  = aw_ready_i;
  assign tid[EV_WR_TXN]  = aw_id_i;
  assign vld[EV_RD_BEAT] = r_valid_i;
  assign rdy[EV_RD_BEAT] = r_ready_i;
  assign tid[EV_RD_BEAT] = r_id_i;

  for (genvar k = 0; k < NUM_EV; k++) begin : g_ev
    axf_event_pulse #(.ID_W(ID_W)) u_pulse (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .valid_i  (vld[k]),
      .ready_i  (rdy[k]),
      .txn_id_i (tid[k]),
      .en_i     (en[k]),
      .mask_i   (mask),
      .ref_id_i (ref_id),
      .pulse_o  (pulse[k])
    );
  end

  assign ev_rd_txn_o  = pulse[EV_RD_TXN];
  assign ev_wr_txn_o  = pulse[EV_WR_TXN];
  assign ev_rd_beat_o = pulse[EV_RD_BEAT];

  p_rd_from_ar_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rd_txn_o |-> $past(ar_valid_i && ar_ready_i));

  p_wr_from_aw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_wr_txn_o |-> $past(aw_valid_i && aw_ready_i));

  p_beat_from_r_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_rd_beat_o |-> $past(r_valid_i && r_ready_i));
endmodule

// File: tb/axi_idflt_events_bench.sv
`timescale 1ns/1ps
module axi_idflt_events_bench;
  localparam int ID_W = 18;
  localparam int NV   = 10;

  typedef struct packed {
    logic [31:0]     ctrl;
    logic [ID_W-1:0] rid;
    logic [1:0]      ar;
    logic [ID_W-1:0] ar_id;
    logic [1:0]      aw;
    logic [ID_W-1:0] aw_id;
    logic [1:0]      r;
    logic [ID_W-1:0] r_id;
    logic [2:0]      exp;   // {rd_txn, wr_txn, rd_beat}
  } vec_t;

  // Vectors cover R4, R5, R6, R7 and R8.
  localparam vec_t VEC [NV] = '{
    '{32'hE000_0000, 18'h00000, 2'b11, 18'h1ABCD, 2'b11, 18'h00F00, 2'b11, 18'h3FFFF, 3'b111},
    '{32'hE003_FFFF, 18'h12345, 2'b11, 18'h12345, 2'b11, 18'h12344, 2'b11, 18'h12345, 3'b101},
    '{32'hE000_00FF, 18'h000AB, 2'b11, 18'h3FFAB, 2'b11, 18'h001AB, 2'b11, 18'h000AC, 3'b110},
    '{32'h8003_FFFF, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 3'b100},
    '{32'h4003_FFFF, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 3'b010},
    '{32'h2003_FFFF, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 3'b001},
    '{32'hE003_FFFF, 18'h00005, 2'b10, 18'h00005, 2'b01, 18'h00005, 2'b11, 18'h00005, 3'b001},
    '{32'h0003_FFFF, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 2'b11, 18'h00005, 3'b000},
    '{32'hE002_0000, 18'h20000, 2'b11, 18'h3FFFF, 2'b11, 18'h1FFFF, 2'b11, 18'h20000, 3'b101},
    '{32'hE000_0001, 18'h00000, 2'b11, 18'h00002, 2'b11, 18'h00003, 2'b11, 18'h00000, 3'b101}
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cfg_we_i = 1'b0;
  logic [7:0]      cfg_addr_i = '0;
  logic [31:0]     cfg_wdata_i = '0;
  logic [31:0]     cfg_rdata_o;
  logic            ar_valid_i = 1'b0, ar_ready_i = 1'b0;
  logic [ID_W-1:0] ar_id_i = '0;
  logic            aw_valid_i = 1'b0, aw_ready_i = 1'b0;
  logic [ID_W-1:0] aw_id_i = '0;
  logic            r_valid_i = 1'b0, r_ready_i = 1'b0;
  logic [ID_W-1:0] r_id_i = '0;
  logic            ev_rd_txn_o, ev_wr_txn_o, ev_rd_beat_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  axi_idflt_events #(.ID_W(ID_W), .ADDR_W(8)) u_axi_idflt_events (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i, .cfg_rdata_o,
    .ar_valid_i, .ar_ready_i, .ar_id_i,
    .aw_valid_i, .aw_ready_i, .aw_id_i,
    .r_valid_i, .r_ready_i, .r_id_i,
    .ev_rd_txn_o, .ev_wr_txn_o, .ev_rd_beat_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    cfg_addr_i = a;
    #1 d = cfg_rdata_o;
  endtask

  task automatic bus_idle();
    ar_valid_i = 0; ar_ready_i = 0; aw_valid_i = 0; aw_ready_i = 0;
    r_valid_i = 0; r_ready_i = 0;
  endtask

  function automatic logic [2:0] ev_now();
    return {ev_rd_txn_o, ev_wr_txn_o, ev_rd_beat_o};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int cnt;
    logic [ID_W-1:0] burst [4];
    burst = '{18'h7, 18'h7, 18'h9, 18'h7};

    // R1: reset state
    repeat (3) @(negedge clk_i);
    ar_valid_i = 1; ar_ready_i = 1; r_valid_i = 1; r_ready_i = 1;
    @(negedge clk_i);
    check("R1 outputs", {29'd0, ev_now()}, 32'd0);
    rd_reg(8'h00, rd); check("R1 ctrl", rd, 32'd0);
    rd_reg(8'h04, rd); check("R1 id", rd, 32'd0);
    bus_idle();
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R2 / R3: register layout and reserved bits
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, rd); check("R2 ctrl readback", rd, 32'hE003_FFFF);
    wr_reg(8'h04, 32'hFFFF_FFFF);
    rd_reg(8'h04, rd); check("R3 id readback", rd, 32'h0003_FFFF);
    wr_reg(8'h08, 32'h0000_0000);
    rd_reg(8'h08, rd); check("R3 stray offset reads 0", rd, 32'd0);
    rd_reg(8'h00, rd); check("R3 ctrl untouched", rd, 32'hE003_FFFF);
    rd_reg(8'h04, rd); check("R3 id untouched", rd, 32'h0003_FFFF);

    // vector table: R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      wr_reg(8'h00, VEC[i].ctrl);
      wr_reg(8'h04, 32'(VEC[i].rid));
      @(negedge clk_i);
      {ar_valid_i, ar_ready_i} = VEC[i].ar; ar_id_i = VEC[i].ar_id;
      {aw_valid_i, aw_ready_i} = VEC[i].aw; aw_id_i = VEC[i].aw_id;
      {r_valid_i, r_ready_i}   = VEC[i].r;  r_id_i  = VEC[i].r_id;
      @(negedge clk_i);
      bus_idle();
      check($sformatf("R5 R6 R7 vec%0d pulses", i), {29'd0, ev_now()}, {29'd0, VEC[i].exp});
      @(negedge clk_i);
      check($sformatf("R8 vec%0d single cycle", i), {29'd0, ev_now()}, 32'd0);
    end

    // R7: beat burst with one mismatching ID
    wr_reg(8'h00, 32'hE003_FFFF);
    wr_reg(8'h04, 32'h0000_0007);
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      r_valid_i = 1; r_ready_i = 1; r_id_i = burst[i];
      @(negedge clk_i);
      check($sformatf("R7 beat %0d", i), {31'd0, ev_rd_beat_o}, {31'd0, burst[i] == 18'h7});
      cnt += int'(ev_rd_beat_o);
    end
    bus_idle();
    check("R7 burst count", cnt, 3);

    // R9: handshake in the cycle of a disabling write uses old config
    wr_reg(8'h04, 32'h0000_0055);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 8'h00; cfg_wdata_i = 32'h0;
    ar_valid_i = 1; ar_ready_i = 1; ar_id_i = 18'h55;
    @(negedge clk_i);
    cfg_we_i = 0;
    check("R9 old config governs", {31'd0, ev_rd_txn_o}, 32'd1);
    @(negedge clk_i);
    bus_idle();
    check("R9 new config governs", {31'd0, ev_rd_txn_o}, 32'd0);

    // R9: enabling write, same-cycle beat ignored, next counted
    @(negedge clk_i);
    cfg_we_i = 1; cfg_addr_i = 8'h00; cfg_wdata_i = 32'h2003_FFFF;
    r_valid_i = 1; r_ready_i = 1; r_id_i = 18'h55;
    @(negedge clk_i);
    cfg_we_i = 0;
    check("R9 enable not yet active", {31'd0, ev_rd_beat_o}, 32'd0);
    @(negedge clk_i);
    bus_idle();
    check("R9 enable active", {31'd0, ev_rd_beat_o}, 32'd1);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule